// File: doc/BRIEF.md
# Condition-Register Flag Update Unit

This block is the integer add, subtract and compare stage of a processor, together with the status state those operations update. It keeps a condition register of eight 4-bit fields and a 3-bit exception status word. Each cycle it takes one operation with two register operands, a 16-bit immediate and a set of per-operation enables. The enables choose whether the result is recorded into condition field 0, whether signed overflow is recorded, and whether an extended add records its carry. Compare operations can write any chosen condition field.

The summary-overflow bit is sticky. It collects every recorded overflow and is cleared only by a dedicated strobe. Its value is copied into the summary position of every condition field the block writes. A plain add with every enable low leaves all status untouched. This lets a compiler place arithmetic between a flag-setting instruction and the branch that tests it. All outputs are registered: an operation presented before a rising clock edge is visible on the outputs after that edge.

Top module: `crflag_unit`

## Requirements
- R1: After a synchronous reset, `result`, `cr` and `xer` are all zero.
- R2: Opcode encodings: 0 no-op, 1 add (a+b), 2 add-immediate (a plus sign-extended imm), 3 subtract-from (b−a), 4 negate (0−a), 5 extended add (a+b+carry bit). The arithmetic result is truncated to 32 bits and appears on `result` one cycle later. Compares and the no-op leave `result` unchanged.
- R3: An arithmetic operation with `rec_en`, `ov_en` and `ca_en` all low changes neither `cr` nor `xer`.
- R4: Condition field k occupies `cr[31-4k:28-4k]`, and within a field bit 3 is LT, bit 2 GT, bit 1 EQ and bit 0 SO. An arithmetic operation with `rec_en` high writes field 0 from a signed comparison of the result against zero. Its SO bit is the summary-overflow value `xer` takes at the same edge. Other fields are unchanged.
- R5: `xer` bit 2 is SO, bit 1 OV and bit 0 CA. An arithmetic operation with `ov_en` high sets OV to the signed overflow of the operation, and ORs that value into SO. Without `ov_en`, OV keeps its value.
- R6: SO stays set until `clr_so` is high at an edge, which clears it. This holds for any operation, and the clear wins over an overflow recorded in the same cycle.
- R7: CA is written only by the extended add with `ca_en` high, which loads the carry out of bit 31. `ca_en` has no effect on any other opcode.
- R8: Opcodes 6 and 7 compare `opnd_a` with `opnd_b`, signed and unsigned respectively. Opcodes 8 and 9 compare `opnd_a` with the sign-extended `imm`, signed and unsigned respectively. A compare writes LT, GT and EQ of field `fld_sel`, or of field 0 when `fld_use` is low. The SO bit of that field is the new SO value. Other fields, `result`, OV and CA are unchanged, and `rec_en` and `ov_en` have no effect.
- R9: The no-op and unused opcodes change nothing except through `clr_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate, sign-extended before use |
| rec_en | input | 1 | Record arithmetic result into field 0 |
| ov_en | input | 1 | Record signed overflow |
| ca_en | input | 1 | Record carry (extended add only) |
| fld_use | input | 1 | Compare targets `fld_sel` instead of field 0 |
| fld_sel | input | 3 | Compare target field index |
| clr_so | input | 1 | Clear summary overflow |
| result | output | 32 | Registered arithmetic result |
| cr | output | 32 | Condition register, field 0 in the top nibble |
| xer | output | 3 | Status bits {SO, OV, CA} |

## Verification
The assertions watch, on every cycle, the properties that follow from the control inputs alone. They check that SO is sticky and that the clear always wins. They check that a flag-free add disturbs no status, that CA moves only on an enabled extended add, that compares never touch OV, and that negating the most negative number records overflow. The numeric side needs the bench's reference model. This covers results of each arithmetic form, the LT/GT/EQ derivation, signed versus unsigned ordering, and placement of a compare into the chosen field while the other seven keep their values. Directed cases cover overflow boundaries, carry out of all-ones, and a clear in the same cycle as an overflow.

// File: rtl/crflag_pkg.sv
package crflag_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDI  = 4'd2,
    OP_SUBF  = 4'd3,
    OP_NEG   = 4'd4,
    OP_ADDX  = 4'd5,
    OP_CMPS  = 4'd6,
    OP_CMPU  = 4'd7,
    OP_CMPSI = 4'd8,
    OP_CMPUI = 4'd9
  } op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crfld_t;

  function automatic logic is_arith(op_e o);
    return (o == OP_ADD) || (o == OP_ADDI) || (o == OP_SUBF) ||
           (o == OP_NEG) || (o == OP_ADDX);
  endfunction

  function automatic logic is_cmp(op_e o);
    return (o == OP_CMPS) || (o == OP_CMPU) || (o == OP_CMPSI) ||
           (o == OP_CMPUI);
  endfunction

endpackage

// File: rtl/crflag_adder.sv
module crflag_adder
  import crflag_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [IMMW-1:0] imm,
  input  logic         ca_in,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   wide;

  // Every form maps onto x + y + cin; subtraction uses the inverted operand.
  always_comb begin
    x   = '0;
    y   = '0;
    cin = 1'b0;
    unique case (op)
      OP_ADD:  begin x = a; y = b; end
      OP_ADDI: begin x = a; y = {{(W-IMMW){imm[IMMW-1]}}, imm}; end
      OP_SUBF: begin x = b; y = ~a; cin = 1'b1; end
      OP_NEG:  begin x = '0; y = ~a; cin = 1'b1; end
      OP_ADDX: begin x = a; y = b; cin = ca_in; end
      default: ;
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/crflag_cmp.sv
module crflag_cmp
  import crflag_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [IMMW-1:0] imm,
  output logic         lt,
  output logic         gt,
  output logic         eq
);

  logic [W-1:0] rhs;
  logic         use_imm, unsgn;

  assign use_imm = (op == OP_CMPSI) || (op == OP_CMPUI);
  assign unsgn   = (op == OP_CMPU)  || (op == OP_CMPUI);
  assign rhs     = use_imm ? {{(W-IMMW){imm[IMMW-1]}}, imm} : b;

  always_comb begin
    eq = (a == rhs);
    if (unsgn) begin
      lt = a < rhs;
      gt = a > rhs;
    end else begin
      lt = $signed(a) < $signed(rhs);
      gt = $signed(a) > $signed(rhs);
    end
  end

endmodule

// File: rtl/crflag_cr.sv
module crflag_cr
  import crflag_pkg::*;
#(
  parameter int NFLD = 8,
  localparam int FW   = $bits(crfld_t),
  localparam int CRW  = NFLD * FW,
  localparam int SELW = (NFLD > 1) ? $clog2(NFLD) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_idx,
  input  crfld_t          wr_val,
  output logic [CRW-1:0]  cr
);

  // Field 0 sits in the most significant nibble.
  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    crfld_t fld_q;
    always_ff @(posedge clk) begin
      if (rst)
        fld_q <= '0;
      else if (wr_en && (wr_idx == SELW'(i)))
        fld_q <= wr_val;
    end
    assign cr[CRW-1-FW*i -: FW] = fld_q;
  end

endmodule

// File: rtl/crflag_unit.sv
module crflag_unit
  import crflag_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16,
  parameter int NFLD = 8,
  localparam int CRW  = NFLD * 4,
  localparam int SELW = (NFLD > 1) ? $clog2(NFLD) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [IMMW-1:0] imm,
  input  logic            rec_en,
  input  logic            ov_en,
  input  logic            ca_en,
  input  logic            fld_use,
  input  logic [SELW-1:0] fld_sel,
  input  logic            clr_so,
  output logic [W-1:0]    result,
  output logic [CRW-1:0]  cr,
  output logic [2:0]      xer
);

  op_e          op_i;
  logic         arith, cmp;
  logic [W-1:0] sum;
  logic         cout, ovf;
  logic         c_lt, c_gt, c_eq;
  logic         so_q, ov_q, ca_q, so_d;
  logic [W-1:0] res_q;
  logic            cr_we;
  logic [SELW-1:0] cr_idx;
  crfld_t          cr_val;

  assign op_i  = op_e'(op);
  assign arith = is_arith(op_i);
  assign cmp   = is_cmp(op_i);

  crflag_adder #(.W(W), .IMMW(IMMW)) u_add (
    .op(op_i), .a(opnd_a), .b(opnd_b), .imm(imm), .ca_in(ca_q),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  crflag_cmp #(.W(W), .IMMW(IMMW)) u_cmp (
    .op(op_i), .a(opnd_a), .b(opnd_b), .imm(imm),
    .lt(c_lt), .gt(c_gt), .eq(c_eq)
  );

  // Clear has priority over any newly recorded overflow.
  assign so_d = clr_so ? 1'b0 : (so_q | (arith & ov_en & ovf));

  always_comb begin
    cr_we  = 1'b0;
    cr_idx = '0;
    cr_val = '0;
    if (arith && rec_en) begin
      cr_we  = 1'b1;
      cr_val = '{lt: sum[W-1], gt: !sum[W-1] && (sum != '0),
                 eq: (sum == '0), so: so_d};
    end else if (cmp) begin
      cr_we  = 1'b1;
      cr_idx = fld_use ? fld_sel : '0;
      cr_val = '{lt: c_lt, gt: c_gt, eq: c_eq, so: so_d};
    end
  end

  crflag_cr #(.NFLD(NFLD)) u_cr (
    .clk(clk), .rst(rst), .wr_en(cr_we), .wr_idx(cr_idx),
    .wr_val(cr_val), .cr(cr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q  <= 1'b0;
      ov_q  <= 1'b0;
      ca_q  <= 1'b0;
      res_q <= '0;
    end else begin
      so_q <= so_d;
      if (arith && ov_en)
        ov_q <= ovf;
      if ((op_i == OP_ADDX) && ca_en)
        ca_q <= cout;
      if (arith)
        res_q <= sum;
    end
  end

  assign result = res_q;
  assign xer    = {so_q, ov_q, ca_q};

endmodule

// File: rtl/crflag_chk.sv
module crflag_chk
  import crflag_pkg::*;
#(
  parameter int W    = 32,
  parameter int NFLD = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      op,
  input logic [W-1:0]    opnd_a,
  input logic            rec_en,
  input logic            ov_en,
  input logic            ca_en,
  input logic            clr_so,
  input logic [NFLD*4-1:0] cr,
  input logic [2:0]      xer
);

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (xer[2] && !clr_so) |=> xer[2]); // R6

  AST_SO_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_so |=> !xer[2]); // R6

  AST_PLAIN_ADD_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_ADD) && !rec_en && !ov_en && !ca_en && !clr_so)
      |=> ($stable(cr) && $stable(xer))); // R3

  AST_CA_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((op != OP_ADDX) || !ca_en) |=> $stable(xer[0])); // R7

  AST_CMP_KEEPS_OV: assert property (@(posedge clk) disable iff (rst)
    ((op >= OP_CMPS) && (op <= OP_CMPUI)) |=> $stable(xer[1])); // R8

  AST_NEG_MIN_OVF: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_NEG) && ov_en && !clr_so && (opnd_a == {1'b1, {(W-1){1'b0}}}))
      |=> (xer[1] && xer[2])); // R5

endmodule

bind crflag_unit crflag_chk #(.W(W), .NFLD(NFLD)) u_chk (
  .clk(clk), .rst(rst), .op(op), .opnd_a(opnd_a), .rec_en(rec_en),
  .ov_en(ov_en), .ca_en(ca_en), .clr_so(clr_so), .cr(cr), .xer(xer)
);

// File: tb/sim_crflag_unit.sv
module sim_crflag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        rec_en, ov_en, ca_en, fld_use, clr_so;
  logic [2:0]  fld_sel;
  logic [31:0] result, cr;
  logic [2:0]  xer;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_res, m_cr;
  logic        m_so, m_ov, m_ca;

  always #10 clk = ~clk;

  crflag_unit u0 (
    .clk(clk), .rst(rst), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .rec_en(rec_en), .ov_en(ov_en), .ca_en(ca_en),
    .fld_use(fld_use), .fld_sel(fld_sel), .clr_so(clr_so),
    .result(result), .cr(cr), .xer(xer)
  );

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  // Reference model built from the requirement text.
  task automatic model_step();
    logic signed [33:0] sa, sb, si, full;
    logic [32:0] uw;
    logic arith, cmp, unsg, ovf, so_n;
    logic [31:0] r, rhs;
    logic [3:0]  nib;
    int k;
    sa = 34'(signed'(opnd_a));
    sb = 34'(signed'(opnd_b));
    si = 34'(signed'(imm));
    arith = (op >= 4'd1) && (op <= 4'd5);
    cmp   = (op >= 4'd6) && (op <= 4'd9);
    full = '0; uw = '0;
    case (op)
      4'd1: full = sa + sb;
      4'd2: full = sa + si;
      4'd3: full = sb - sa;
      4'd4: full = -sa;
      4'd5: begin
        full = sa + sb + 34'(m_ca);
        uw   = {1'b0, opnd_a} + {1'b0, opnd_b} + 33'(m_ca);
      end
      default: ;
    endcase
    r   = full[31:0];
    ovf = (full > 34'sh7FFFFFFF) || (full < -34'sh80000000);
    so_n = clr_so ? 1'b0 : (m_so | (arith & ov_en & ovf));
    if (arith) begin
      m_res = r;
      if (ov_en) m_ov = ovf;
      if (op == 4'd5 && ca_en) m_ca = uw[32];
      if (rec_en) begin
        nib = {$signed(r) < 0, $signed(r) > 0, r == 0, so_n};
        m_cr[31:28] = nib;
      end
    end else if (cmp) begin
      rhs  = (op >= 4'd8) ? 32'(si) : opnd_b;
      unsg = (op == 4'd7) || (op == 4'd9);
      if (unsg) nib = {opnd_a < rhs, opnd_a > rhs, opnd_a == rhs, so_n};
      else nib = {$signed(opnd_a) < $signed(rhs), $signed(opnd_a) > $signed(rhs),
                  opnd_a == rhs, so_n};
      k = fld_use ? int'(fld_sel) : 0;
      m_cr[31-4*k -: 4] = nib;
    end
    m_so = so_n;
  endtask

  task automatic run(string tag, logic [3:0] o, logic [31:0] a, logic [31:0] b,
                     logic [15:0] im, logic re, logic oe, logic ce,
                     logic fu, logic [2:0] fs, logic cl);
    op = o; opnd_a = a; opnd_b = b; imm = im; rec_en = re; ov_en = oe;
    ca_en = ce; fld_use = fu; fld_sel = fs; clr_so = cl;
    model_step();
    @(negedge clk);
    check(tag, "result", result, m_res);
    check(tag, "cr", cr, m_cr);
    check(tag, "xer", {29'd0, xer}, {29'd0, m_so, m_ov, m_ca});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    m_res = '0; m_cr = '0; m_so = 0; m_ov = 0; m_ca = 0;
    rst = 1; op = 0; opnd_a = 0; opnd_b = 0; imm = 0; rec_en = 0;
    ov_en = 0; ca_en = 0; fld_use = 0; fld_sel = 0; clr_so = 0;
    repeat (3) @(negedge clk);
    check("R1", "result", result, 32'd0);
    check("R1", "cr", cr, 32'd0);
    check("R1", "xer", {29'd0, xer}, 32'd0);
    rst = 0;

    // R2 / R3: plain add overflows but records nothing
    run("R3", 4'd1, 32'h7FFF_FFFF, 32'd1, 16'd0, 0, 0, 0, 0, 3'd0, 0);
    check("R2", "add result", result, 32'h8000_0000);
    check("R3", "cr untouched", cr, 32'd0);
    // R4 / R5: recorded overflow, negative result
    run("R5", 4'd1, 32'h7FFF_FFFF, 32'd1, 16'd0, 1, 1, 0, 0, 3'd0, 0);
    check("R4", "cr0 LT+SO", cr, 32'h9000_0000);
    check("R5", "xer SO OV", {29'd0, xer}, 32'd6);
    // R6: sticky SO through non-overflowing recorded add
    run("R6", 4'd2, 32'd5, 32'd0, 16'hFFFB, 1, 1, 0, 0, 3'd0, 0);
    check("R6", "cr0 EQ+SO", cr, 32'h3000_0000);
    // R6: clear wins over same-cycle overflow
    run("R6", 4'd1, 32'h8000_0000, 32'h8000_0000, 16'd0, 1, 1, 0, 0, 3'd0, 1);
    check("R6", "xer clear wins", {29'd0, xer}, 32'd2);
    // R2 / R5: subtract-from and negate of most negative
    run("R2", 4'd3, 32'd10, 32'd3, 16'd0, 1, 1, 0, 0, 3'd0, 0);
    check("R2", "subf", result, 32'hFFFF_FFF9);
    run("R5", 4'd4, 32'h8000_0000, 32'd0, 16'd0, 0, 1, 0, 0, 3'd0, 0);
    check("R5", "neg min OV", {29'd0, xer[2:1]}, 32'd3);
    // R7: extended add carry, then ca_en ignored on plain add
    run("R7", 4'd5, 32'hFFFF_FFFF, 32'd1, 16'd0, 1, 0, 1, 0, 3'd0, 1);
    check("R7", "CA set", {31'd0, xer[0]}, 32'd1);
    run("R7", 4'd1, 32'd1, 32'd1, 16'd0, 0, 0, 1, 0, 3'd0, 0);
    run("R7", 4'd5, 32'd1, 32'd1, 16'd0, 0, 0, 1, 0, 3'd0, 0);
    check("R7", "addx uses carry", result, 32'd3);
    // R8: signed vs unsigned into field 5, immediate into field 0
    run("R8", 4'd6, 32'hFFFF_FFFF, 32'd1, 16'd0, 1, 1, 0, 1, 3'd5, 0);
    check("R8", "signed LT f5", {28'd0, cr[11:8]}, 32'h8);
    run("R8", 4'd7, 32'hFFFF_FFFF, 32'd1, 16'd0, 0, 0, 0, 1, 3'd6, 0);
    check("R8", "unsigned GT f6", {28'd0, cr[7:4]}, 32'h4);
    run("R8", 4'd9, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 0, 0, 0, 0, 3'd7, 0);
    check("R8", "imm EQ f0", {28'd0, cr[31:28]}, 32'h2);
    // R9: nop and unused opcode
    run("R9", 4'd0, 32'd7, 32'd7, 16'd7, 1, 1, 1, 1, 3'd2, 0);
    run("R9", 4'd14, 32'd7, 32'd7, 16'd7, 1, 1, 1, 1, 3'd2, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 10));
      if (o == 4'd10) o = 4'd15;
      run((o >= 4'd6 && o <= 4'd9) ? "R8" : ((o == 4'd0 || o > 4'd9) ? "R9" : "R4"),
          o, pick(), pick(), 16'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 3'($urandom),
          ($urandom_range(0, 15) == 0));
    end
    finish_run();
  end

endmodule